// File: doc/BRIEF.md
# Converter Selection Register with Commit-on-Completion

This block is the software-visible 8-bit selection register that sits in front of an analog-to-digital converter, together with the path that presents the converter's 10-bit result as a 16-bit readable word. Software writes three fields: a 2-bit reference choice, a 1-bit result-justification flag and a 4-bit input channel number. The register reads back whatever was last written, with its one unused bit always zero.

The reference and channel values that actually drive the converter front end live in a separate applied copy. While the conversion sequencer reports a conversion in flight, that copy is frozen. It is reloaded from the written register only when the sequencer pulses its completion strobe. When no conversion is running, a write reaches the applied copy on the next clock edge. The justification flag is different: it shapes the formatted result as soon as it is written, whether or not a conversion is running.

Top module: `adc_ctrl_reg`

## Requirements
- R1: After reset, the read-back register, the applied reference, the applied channel and the justification flag are all zero.
- R2: The register layout is reference in bits 7:6, justification flag in bit 5, an unused bit 4 and channel in bits 3:0. A read returns the last written value, including fields not yet applied.
- R3: Bit 4 always reads as zero, and writing a one to it changes no output.
- R4: When `conv_busy` is low, a written reference and channel appear on `ref_sel` and `chan_sel` on the clock edge that takes the write.
- R5: While `conv_busy` is high and `conv_done` is low, `ref_sel` holds its value even if a new reference is written.
- R6: While `conv_busy` is high and `conv_done` is low, `chan_sel` holds its value even if a new channel is written.
- R7: On the edge where `conv_done` is high, `ref_sel` and `chan_sel` take the reference and channel from the register.
- R8: If a write and `conv_done` fall in the same cycle, the newly written reference and channel are the ones applied.
- R9: A change to the justification flag changes `data_out` in the cycle after the write, even while a conversion is busy.
- R10: With the flag at 0, `data_out[9:0]` equals `raw_result` and bits 15:10 are zero.
- R11: With the flag at 1, `data_out[15:6]` equals `raw_result` and bits 5:0 are zero.
- R12: All four reference codes are stored and forwarded as written, with no error indication: 00 is the external pin with the internal source off, 01 is the analog supply, 10 is reserved, and 11 is the internal fixed reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read-back, bit 4 zero |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | Conversion-complete strobe, one cycle |
| raw_result | input | 10 | Raw converter result |
| ref_sel | output | 2 | Applied reference selection |
| chan_sel | output | 4 | Applied channel selection |
| data_out | output | 16 | Formatted result word |

## Verification
The bench writes new reference and channel values in the middle of a busy conversion. A design that forwarded them at once would change `ref_sel` or `chan_sel` before the completion strobe. It writes and strobes completion in the same cycle, where a design that committed the old stored value would apply a stale selection for a whole conversion. It toggles the justification flag during a busy conversion to catch a design that wrongly defers that flag along with the other fields. It also writes the reserved reference code and a one into bit 4, so that a design that filters the code or keeps the unused bit would show it at the ports.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int REG_W  = 8;
  localparam int REF_W  = 2;
  localparam int CHAN_W = 4;
  localparam int RAW_W  = 10;
  localparam int DATA_W = 16;
  localparam int PAD_W  = DATA_W - RAW_W;

  // bit positions: the layout is software-visible, so it is fixed
  localparam int REF_LSB  = 6;
  localparam int ADJ_BIT  = 5;
  localparam int CHAN_LSB = 0;

  typedef enum logic [REF_W-1:0] {
    REF_EXT_PIN = 2'b00,
    REF_SUPPLY  = 2'b01,
    REF_RSVD    = 2'b10,
    REF_FIXED   = 2'b11
  } ref_code_e;

  typedef struct packed {
    logic [REF_W-1:0]  refs;
    logic              left;
    logic [CHAN_W-1:0] chan;
  } sel_fields_t;

  function automatic sel_fields_t unpack_ctrl(input logic [REG_W-1:0] b);
    sel_fields_t f;
    f.refs = b[REF_LSB +: REF_W];
    f.left = b[ADJ_BIT];
    f.chan = b[CHAN_LSB +: CHAN_W];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input sel_fields_t f);
    logic [REG_W-1:0] b;
    b = '0;
    b[REF_LSB +: REF_W]   = f.refs;
    b[ADJ_BIT]            = f.left;
    b[CHAN_LSB +: CHAN_W] = f.chan;
    return b;
  endfunction

  function automatic logic [DATA_W-1:0] fmt_result(input logic [RAW_W-1:0] raw,
                                                   input logic left);
    if (left) return {raw, {PAD_W{1'b0}}};
    return {{PAD_W{1'b0}}, raw};
  endfunction
endpackage

// File: rtl/adc_ctrl_store.sv
module adc_ctrl_store
  import adc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output sel_fields_t      cur,
  output sel_fields_t      nxt
);
  always_comb nxt = wr_en ? unpack_ctrl(wr_data) : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // R2
  store_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cur == unpack_ctrl($past(wr_data))));
endmodule

// File: rtl/adc_ctrl_commit.sv
module adc_ctrl_commit
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [REF_W-1:0]  nxt_ref,
  input  logic [CHAN_W-1:0] nxt_chan,
  input  logic [REF_W-1:0]  held_ref,
  input  logic [CHAN_W-1:0] held_chan,
  output logic [REF_W-1:0]  ref_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic              commit_evt
);
  // the applied copy may move when idle or at the completion strobe
  assign commit_evt = !conv_busy || conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      chan_q <= '0;
    end else if (commit_evt) begin
      ref_q  <= nxt_ref;
      chan_q <= nxt_chan;
    end
  end

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> $stable(ref_q));
  // R6
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> $stable(chan_q));
  // R7
  commit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (ref_q == held_ref) && (chan_q == held_chan));
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt
  import adc_ctrl_pkg::*;
(
  input  logic [RAW_W-1:0]  raw,
  input  logic              left,
  output logic [DATA_W-1:0] data
);
  always_comb data = fmt_result(raw, left);
endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  output logic [7:0]  rd_data,
  input  logic        conv_busy,
  input  logic        conv_done,
  input  logic [9:0]  raw_result,
  output logic [1:0]  ref_sel,
  output logic [3:0]  chan_sel,
  output logic [15:0] data_out
);
  sel_fields_t cur_f, nxt_f;
  logic        commit_evt;

  adc_ctrl_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cur(cur_f), .nxt(nxt_f)
  );

  adc_ctrl_commit u_commit (
    .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .conv_done(conv_done),
    .nxt_ref(nxt_f.refs), .nxt_chan(nxt_f.chan),
    .held_ref(cur_f.refs), .held_chan(cur_f.chan),
    .ref_q(ref_sel), .chan_q(chan_sel), .commit_evt(commit_evt)
  );

  adc_result_fmt u_fmt (
    .raw(raw_result), .left(cur_f.left), .data(data_out)
  );

  assign rd_data = pack_ctrl(cur_f);

  // R10
  right_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[ADJ_BIT] |-> (data_out[15:10] == '0) && (data_out[9:0] == raw_result));
  // R11
  left_adjust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[ADJ_BIT] |-> (data_out[5:0] == '0) && (data_out[15:6] == raw_result));
  // R4
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !conv_busy) |=> (ref_sel == $past(wr_data[7:6])) && (chan_sel == $past(wr_data[3:0])));
  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && conv_done) |=> (ref_sel == $past(wr_data[7:6])) && (chan_sel == $past(wr_data[3:0])));
endmodule

// File: tb/adc_ctrl_reg_bench.sv
module adc_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        conv_busy = 1'b0;
  logic        conv_done = 1'b0;
  logic [9:0]  raw_result = '0;
  logic [1:0]  ref_sel;
  logic [3:0]  chan_sel;
  logic [15:0] data_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_ctrl_reg u_adc_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .conv_busy(conv_busy), .conv_done(conv_done), .raw_result(raw_result),
    .ref_sel(ref_sel), .chan_sel(chan_sel), .data_out(data_out)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] view(input logic [9:0] r, input logic l);
    return l ? ({6'b0, r} << 6) : {6'b0, r};
  endfunction

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd", {8'h0, rd_data}, 16'h0);
    chk("R1 ref", {14'h0, ref_sel}, 16'h0);
    chk("R1 chan", {12'h0, chan_sel}, 16'h0);
    raw_result = 10'h3FF; #1;
    chk("R1 flag", data_out, 16'h03FF);
  endtask

  task automatic t_idle;
    raw_result = 10'h155;
    wr(8'h47);
    chk("R2 rd", {8'h0, rd_data}, 16'h0047);
    chk("R4 ref", {14'h0, ref_sel}, 16'h1);
    chk("R4 chan", {12'h0, chan_sel}, 16'h7);
    chk("R10 right", data_out, view(10'h155, 1'b0));
    wr(8'h5A);
    chk("R3 rd", {8'h0, rd_data}, 16'h004A);
    chk("R3 chan", {12'h0, chan_sel}, 16'hA);
  endtask

  task automatic t_busy_hold;
    @(negedge clk); conv_busy = 1'b1;
    wr(8'hC3);
    chk("R2 pending rd", {8'h0, rd_data}, 16'h00C3);
    chk("R5 ref held", {14'h0, ref_sel}, 16'h1);
    chk("R6 chan held", {12'h0, chan_sel}, 16'hA);
    repeat (3) @(negedge clk);
    chk("R5 ref still", {14'h0, ref_sel}, 16'h1);
    chk("R6 chan still", {12'h0, chan_sel}, 16'hA);
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0; conv_busy = 1'b0;
    chk("R7 ref", {14'h0, ref_sel}, 16'h3);
    chk("R7 chan", {12'h0, chan_sel}, 16'h3);
  endtask

  task automatic t_adjust_busy;
    raw_result = 10'h2A5;
    @(negedge clk); conv_busy = 1'b1;
    wr(8'h63);
    chk("R9 R11 left now", data_out, 16'hA940);
    chk("R5 ref held", {14'h0, ref_sel}, 16'h3);
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0; conv_busy = 1'b0;
    chk("R7 ref", {14'h0, ref_sel}, 16'h1);
  endtask

  task automatic t_same_cycle;
    @(negedge clk); conv_busy = 1'b1;
    wr(8'h05);
    conv_done = 1'b1; wr_en = 1'b1; wr_data = 8'h8B;
    @(negedge clk); conv_done = 1'b0; wr_en = 1'b0; conv_busy = 1'b0;
    chk("R8 R12 ref", {14'h0, ref_sel}, 16'h2);
    chk("R8 chan", {12'h0, chan_sel}, 16'hB);
    chk("R12 rd", {8'h0, rd_data}, 16'h008B);
  endtask

  task automatic t_full;
    raw_result = 10'h3FF;
    wr(8'hFF);
    chk("R3 rd", {8'h0, rd_data}, 16'h00EF);
    chk("R12 ref", {14'h0, ref_sel}, 16'h3);
    chk("R11 left", data_out, 16'hFFC0);
    wr(8'h00);
    chk("R12 ref ext", {14'h0, ref_sel}, 16'h0);
    chk("R10 right", data_out, 16'h03FF);
  endtask

  bit finished = 0;

  initial begin
    repeat (2) @(negedge clk);
    #1; t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_idle;
    t_busy_hold;
    t_adjust_busy;
    t_same_cycle;
    t_full;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule